// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is a master-only I2C controller that firmware drives one bus phase at a time through a small word-addressed register set. A phase is a START (or repeated START), the transmission of one byte (address or data), the reception of one byte, or a STOP. When a START, transmit or receive phase finishes, the controller sets a pending flag in the control register and posts an 8-bit code in the status register that says what happened on the bus. It then holds SCL low until firmware writes the control register with the flag bit clear, which launches the next phase.

The bus timing comes from a `tick` input. Each tick advances the running phase by one quarter of a bit period, so one SCL period takes four ticks. Addresses are 7 bits wide. Bit 0 of the address byte selects a read. The block uses open-drain outputs: a 1 on `scl_o` or `sda_o` releases the line, and a 0 pulls it low. The wired SDA level comes back on `sda_i`.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status register (offset 0x0C) reads 0xF8, and the control (0x08), data (0x04), own-address (0x00) and extension (0x10) registers read 0. `scl_o` and `sda_o` are both 1.
- R2: A control write with enable (bit 6) and START (bit 5) set while no transfer is open drives SDA low while SCL is high, then drives SCL low. It then sets the pending flag (control bit 3) and posts status 0x08.
- R3: A START request while a transfer is open (after an earlier START and before a STOP) produces a repeated START and posts status 0x10.
- R4: After status 0x08 or 0x10, a control write with bit 3 clear sends the data register MSB first as an address byte, followed by a ninth acknowledge clock. The posted status is 0x18 or 0x40 when the target pulls SDA low in the ninth clock, and 0x20 or 0x48 when it does not. Of each pair, the second value applies when bit 0 of the byte is 1 (read).
- R5: After status 0x18 or 0x28, clearing the flag sends the data register as a data byte. The posted status is 0x28 when the byte is acknowledged and 0x30 when it is not.
- R6: After status 0x40 or 0x50, clearing the flag receives a byte MSB first into the data register. If control bit 2 (ACK) was set in that write, the controller pulls SDA low in the ninth clock and posts 0x50. If ACK was clear, it releases SDA and posts 0x58. The received byte stays readable at 0x04 while the flag is pending.
- R7: A control write with STOP (bit 4) set clears the pending flag at once. It drives SDA high while SCL is high, posts 0xF8 only when the STOP has finished, and never sets the pending flag.
- R8: Any write to offset 0x1C returns every register, including the own-address and extension registers, to its R1 value and releases both lines.
- R9: While enable is clear, both lines are released and status stays 0xF8. Every other control bit in a control write is ignored, so no bus activity follows. Clearing enable during a transfer aborts it the same way.
- R10: `irq` is 1 exactly when the pending flag and the interrupt-enable bit (control bit 7) are both set.
- R11: SCL and SDA change only on the clock edge that follows a `tick` or a register write. SCL stays low for as long as the flag is pending.
- R12: Offsets 0x00 and 0x10 are read/write byte registers with no effect on the bus. A write to 0x0C does not change the status read there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Quarter-bit timing strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Byte offset of the register accessed |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| scl_o | output | 1 | SCL drive, 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA drive, 0 pulls low, 1 releases |
| sda_i | input | 1 | Wired SDA level |

## Verification
The bench goes after three groups of corner cases.

- **Start-code choice.** A START on a closed bus must post 0x08 and one on an open bus 0x10. A design that forgot to close the bus at STOP would post 0x10 after a fresh START.
- **Ack-driven code pairs.** The bench checks each pair of ack-dependent codes. This includes a NAKed read address, where a design that ignored the direction bit would post 0x20 instead of 0x48. It also checks a receive with ACK clear, where a design that latched the wrong ACK value would acknowledge the last byte and leave the target driving SDA through the STOP.
- **STOP, disable and soft reset.** A design that raised the pending flag at the end of a STOP would fire `irq`. One that did not drop the lines when disabled or soft-reset would leave SCL held low. One that kept the own address across a soft reset would read back a stale value.

// File: rtl/ibe_pkg.sv
package ibe_pkg;

    typedef enum logic [1:0] {
        PH_START = 2'd0,
        PH_STOP  = 2'd1,
        PH_TX    = 2'd2,
        PH_RX    = 2'd3
    } phase_e;

    localparam int DW = 8;

    // posted status codes
    localparam logic [7:0] ST_START  = 8'h08;
    localparam logic [7:0] ST_RSTART = 8'h10;
    localparam logic [7:0] ST_AW_ACK = 8'h18;
    localparam logic [7:0] ST_AW_NAK = 8'h20;
    localparam logic [7:0] ST_DW_ACK = 8'h28;
    localparam logic [7:0] ST_DW_NAK = 8'h30;
    localparam logic [7:0] ST_AR_ACK = 8'h40;
    localparam logic [7:0] ST_AR_NAK = 8'h48;
    localparam logic [7:0] ST_RX_ACK = 8'h50;
    localparam logic [7:0] ST_RX_NAK = 8'h58;
    localparam logic [7:0] ST_IDLE   = 8'hF8;

    // control register bit positions
    localparam int CB_ACK   = 2;
    localparam int CB_FLAG  = 3;
    localparam int CB_STOP  = 4;
    localparam int CB_START = 5;
    localparam int CB_EN    = 6;
    localparam int CB_IE    = 7;

    // register byte offsets
    localparam int OFF_OWN  = 'h00;
    localparam int OFF_DATA = 'h04;
    localparam int OFF_CTRL = 'h08;
    localparam int OFF_STAT = 'h0C;
    localparam int OFF_EXT  = 'h10;
    localparam int OFF_SRST = 'h1C;

endpackage

// File: rtl/ibe_phase_engine.sv
module ibe_phase_engine
    import ibe_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              go,
    input  phase_e            kind,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              ack_low,
    input  logic              sda_i,
    output logic              busy,
    output logic              done,
    output logic              ack_seen,
    output logic              scl_o,
    output logic              sda_o,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

    typedef struct packed {
        logic              run;
        phase_e            kind;
        logic [1:0]        qtr;
        logic [CNT_W-1:0]  bitn;
        logic [BYTE_W-1:0] sh;
        logic              ack_low;
        logic              ack_seen;
        logic              scl;
        logic              sda;
        logic              done;
    } eng_t;

    eng_t eng_d, eng_q;

    function automatic eng_t idle_val();
        eng_t v;
        v      = '0;
        v.kind = PH_START;
        v.scl  = 1'b1;
        v.sda  = 1'b1;
        return v;
    endfunction

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (clr) begin
            eng_d = idle_val();
        end else if (go && !eng_q.run) begin
            eng_d.run     = 1'b1;
            eng_d.kind    = kind;
            eng_d.qtr     = 2'd0;
            eng_d.bitn    = '0;
            eng_d.sh      = tx_byte;
            eng_d.ack_low = ack_low;
        end else if (tick && eng_q.run) begin
            eng_d.qtr = eng_q.qtr + 2'd1;
            case (eng_q.kind)
                PH_START: begin
                    case (eng_q.qtr)
                        2'd0:    eng_d.sda = 1'b1;
                        2'd1:    eng_d.scl = 1'b1;
                        2'd2:    eng_d.sda = 1'b0;
                        default: begin
                            eng_d.scl  = 1'b0;
                            eng_d.run  = 1'b0;
                            eng_d.done = 1'b1;
                        end
                    endcase
                end
                PH_STOP: begin
                    case (eng_q.qtr)
                        2'd0: begin
                            eng_d.scl = 1'b0;
                            eng_d.sda = 1'b0;
                        end
                        2'd1:    eng_d.scl = 1'b1;
                        2'd2:    eng_d.sda = 1'b1;
                        default: begin
                            eng_d.run  = 1'b0;
                            eng_d.done = 1'b1;
                        end
                    endcase
                end
                default: begin
                    case (eng_q.qtr)
                        2'd0: begin
                            eng_d.scl = 1'b0;
                            if (eng_q.bitn == ACK_SLOT)
                                eng_d.sda = (eng_q.kind == PH_RX) ? !eng_q.ack_low : 1'b1;
                            else
                                eng_d.sda = (eng_q.kind == PH_TX) ? eng_q.sh[BYTE_W-1] : 1'b1;
                        end
                        2'd1: eng_d.scl = 1'b1;
                        2'd2: begin
                            if (eng_q.bitn == ACK_SLOT)
                                eng_d.ack_seen = !sda_i;
                            else
                                eng_d.sh = {eng_q.sh[BYTE_W-2:0], sda_i};
                        end
                        default: begin
                            eng_d.scl = 1'b0;
                            if (eng_q.bitn == ACK_SLOT) begin
                                eng_d.run  = 1'b0;
                                eng_d.done = 1'b1;
                            end else begin
                                eng_d.bitn = eng_q.bitn + 1'b1;
                            end
                        end
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= idle_val();
        else        eng_q <= eng_d;
    end

    assign busy     = eng_q.run;
    assign done     = eng_q.done;
    assign ack_seen = eng_q.ack_seen;
    assign scl_o    = eng_q.scl;
    assign sda_o    = eng_q.sda;
    assign rx_byte  = eng_q.sh;

endmodule

// File: rtl/ibe_status_map.sv
module ibe_status_map
    import ibe_pkg::*;
(
    input  phase_e     kind,
    input  logic       addr_byte,
    input  logic       rd_mode,
    input  logic       acked,
    input  logic       ack_given,
    input  logic       was_open,
    output logic [7:0] code
);

    always_comb begin
        case (kind)
            PH_START: code = was_open ? ST_RSTART : ST_START;
            PH_STOP:  code = ST_IDLE;
            PH_TX: begin
                if (addr_byte && rd_mode)
                    code = acked ? ST_AR_ACK : ST_AR_NAK;
                else if (addr_byte)
                    code = acked ? ST_AW_ACK : ST_AW_NAK;
                else
                    code = acked ? ST_DW_ACK : ST_DW_NAK;
            end
            default:  code = ack_given ? ST_RX_ACK : ST_RX_NAK;
        endcase
    end

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import ibe_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq,
    output logic              scl_o,
    output logic              sda_o,
    input  logic              sda_i
);

    typedef struct packed {
        logic          en;
        logic          ie;
        logic          ack;
        logic          flag;
        logic [7:0]    status;
        logic [DW-1:0] data;
        logic [DW-1:0] own;
        logic [DW-1:0] ext;
        logic          open;
        logic          rd_mode;
        logic          cur_addr;
        logic          cur_ack;
        phase_e        cur_kind;
    } ctl_t;

    ctl_t st_d, st_q;

    function automatic ctl_t rst_val();
        ctl_t v;
        v          = '0;
        v.status   = ST_IDLE;
        v.cur_kind = PH_START;
        return v;
    endfunction

    logic          eng_go, eng_clr, eng_busy, eng_done, eng_ack;
    phase_e        go_kind;
    logic [DW-1:0] eng_rx;
    logic [7:0]    done_code;

    wire hit_own  = reg_wr && (reg_addr == REG_AW'(OFF_OWN));
    wire hit_data = reg_wr && (reg_addr == REG_AW'(OFF_DATA));
    wire hit_ctrl = reg_wr && (reg_addr == REG_AW'(OFF_CTRL));
    wire hit_ext  = reg_wr && (reg_addr == REG_AW'(OFF_EXT));
    wire hit_srst = reg_wr && (reg_addr == REG_AW'(OFF_SRST));

    always_comb begin
        st_d    = st_q;
        eng_go  = 1'b0;
        go_kind = PH_TX;
        if (hit_srst) begin
            st_d = rst_val();
        end else begin
            if (hit_own)  st_d.own  = reg_wdata;
            if (hit_ext)  st_d.ext  = reg_wdata;
            if (hit_data) st_d.data = reg_wdata;
            if (hit_ctrl) begin
                st_d.en = reg_wdata[CB_EN];
                if (!reg_wdata[CB_EN]) begin
                    st_d.flag   = 1'b0;
                    st_d.open   = 1'b0;
                    st_d.status = ST_IDLE;
                end else if (st_q.en) begin
                    st_d.ie  = reg_wdata[CB_IE];
                    st_d.ack = reg_wdata[CB_ACK];
                    if (!eng_busy) begin
                        if (reg_wdata[CB_STOP]) begin
                            eng_go    = 1'b1;
                            go_kind   = PH_STOP;
                            st_d.flag = 1'b0;
                        end else if (reg_wdata[CB_START]) begin
                            eng_go    = 1'b1;
                            go_kind   = PH_START;
                            st_d.flag = 1'b0;
                        end else if (st_q.flag && !reg_wdata[CB_FLAG]) begin
                            st_d.flag = 1'b0;
                            if (st_q.open) begin
                                case (st_q.status)
                                    ST_START, ST_RSTART: begin
                                        eng_go        = 1'b1;
                                        go_kind       = PH_TX;
                                        st_d.cur_addr = 1'b1;
                                        st_d.rd_mode  = st_q.data[0];
                                    end
                                    ST_AW_ACK, ST_DW_ACK: begin
                                        eng_go        = 1'b1;
                                        go_kind       = PH_TX;
                                        st_d.cur_addr = 1'b0;
                                    end
                                    ST_AR_ACK, ST_RX_ACK: begin
                                        eng_go        = 1'b1;
                                        go_kind       = PH_RX;
                                        st_d.cur_addr = 1'b0;
                                    end
                                    default: ;
                                endcase
                            end
                        end
                    end
                end
                if (eng_go) begin
                    st_d.cur_kind = go_kind;
                    st_d.cur_ack  = reg_wdata[CB_ACK];
                end
            end
            if (eng_done && st_d.en) begin
                st_d.status = done_code;
                case (st_q.cur_kind)
                    PH_START: begin
                        st_d.open = 1'b1;
                        st_d.flag = 1'b1;
                    end
                    PH_STOP:  st_d.open = 1'b0;
                    PH_TX:    st_d.flag = 1'b1;
                    default: begin
                        st_d.flag = 1'b1;
                        st_d.data = eng_rx;
                    end
                endcase
            end
        end
        eng_clr = hit_srst || !st_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= rst_val();
        else        st_q <= st_d;
    end

    assign eng_ack = reg_wdata[CB_ACK];

    ibe_phase_engine #(.BYTE_W(DW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (eng_clr),
        .tick     (tick),
        .go       (eng_go),
        .kind     (go_kind),
        .tx_byte  (st_q.data),
        .ack_low  (eng_ack),
        .sda_i    (sda_i),
        .busy     (eng_busy),
        .done     (eng_done),
        .ack_seen (),
        .scl_o    (scl_o),
        .sda_o    (sda_o),
        .rx_byte  (eng_rx)
    );

    logic eng_acked;
    assign eng_acked = u_eng.ack_seen;

    ibe_status_map u_map (
        .kind      (st_q.cur_kind),
        .addr_byte (st_q.cur_addr),
        .rd_mode   (st_q.rd_mode),
        .acked     (eng_acked),
        .ack_given (st_q.cur_ack),
        .was_open  (st_q.open),
        .code      (done_code)
    );

    always_comb begin
        case (reg_addr)
            REG_AW'(OFF_OWN):  reg_rdata = st_q.own;
            REG_AW'(OFF_DATA): reg_rdata = st_q.data;
            REG_AW'(OFF_CTRL): reg_rdata = {st_q.ie, st_q.en, 2'b00, st_q.flag, st_q.ack, 2'b00};
            REG_AW'(OFF_STAT): reg_rdata = st_q.status;
            REG_AW'(OFF_EXT):  reg_rdata = st_q.ext;
            default:           reg_rdata = '0;
        endcase
    end

    assign irq = st_q.flag && st_q.ie;

endmodule

// File: rtl/ibe_chk.sv
module ibe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       clr,
    input logic       scl_o,
    input logic       sda_o,
    input logic       flag,
    input logic [7:0] status,
    input logic       en,
    input logic       busy
);

    // R11
    scl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !busy) |-> !scl_o);

    // R11
    tick_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((scl_o != $past(scl_o)) || (sda_o != $past(sda_o))) |-> ($past(tick) || $past(clr)));

    // R7
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status == 8'hF8) && ($past(status) != 8'hF8)) |-> !flag);

    // R2
    flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (en && (status != 8'hF8)));

    // R9
    off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (scl_o && sda_o));

endmodule

bind i2c_byte_master ibe_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clr    (eng_clr),
    .scl_o  (scl_o),
    .sda_o  (sda_o),
    .flag   (st_q.flag),
    .status (st_q.status),
    .en     (st_q.en),
    .busy   (eng_busy)
);

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, scl_o, sda_o, sda_i;
    logic       slv_drv = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    assign sda_i = sda_o & slv_drv;

    i2c_byte_master dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // tick every fourth clock
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cnt  = (cnt + 1) % 4;
            tick = (cnt == 0);
        end
    end

    // per-clock model: lines move only after a tick or a register write (R11)
    initial begin
        logic ps = 1'b1, pd = 1'b1, tk, w;
        forever begin
            @(posedge clk);
            tk = tick; w = reg_wr;
            #2;
            if (rst_n) begin
                checks++;
                if (((scl_o != ps) || (sda_o != pd)) && !tk && !w) begin
                    errors++;
                    $display("FAIL R11: actual line change scl %0b sda %0b expected none", scl_o, sda_o);
                end
            end
            ps = scl_o; pd = sda_o;
        end
    end

    // behavioural target device and bus monitor
    int       n_start = 0, n_stop = 0;
    logic [7:0] wq[$];
    logic [7:0] rq[$];
    bit       slv_ack = 1;
    bit       m_ack = 0;
    initial begin
        logic p_scl = 1, p_sda = 1, scl, sda, rw = 0, addr_ph = 0, go_on = 0;
        logic [7:0] inb = 0, txb = 8'hFF;
        int bitc = -1, old;
        forever begin
            @(negedge clk);
            scl = scl_o; sda = sda_i;
            if (p_scl && scl && p_sda && !sda) begin
                n_start++; bitc = -1; addr_ph = 1; slv_drv = 1;
            end else if (p_scl && scl && !p_sda && sda) begin
                n_stop++; bitc = -1; addr_ph = 0; slv_drv = 1;
            end else if (!p_scl && scl) begin
                if (bitc >= 0 && bitc < 8) inb = {inb[6:0], sda};
                else if (bitc == 8) m_ack = !sda;
            end else if (p_scl && !scl) begin
                old = bitc;
                slv_drv = 1;
                if (old == 8 || old == -1) begin
                    bitc = 0;
                    if (old == 8) begin
                        if (addr_ph) begin addr_ph = 0; go_on = rw && go_on; end
                        else if (rw) go_on = m_ack;
                        else go_on = 0;
                        if (go_on) begin
                            txb = (rq.size() > 0) ? rq.pop_front() : 8'hFF;
                            slv_drv = txb[7];
                        end
                    end
                end else if (old == 7) begin
                    bitc = 8;
                    if (addr_ph || !rw) begin
                        wq.push_back(inb);
                        if (addr_ph) rw = inb[0];
                        slv_drv = !slv_ack;
                        go_on = slv_ack;
                    end
                end else begin
                    bitc = old + 1;
                    if (rw && !addr_ph && go_on) slv_drv = txb[7 - bitc];
                end
            end
            p_scl = scl; p_sda = sda;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_flag();
        logic [7:0] v;
        for (int i = 0; i < 1000; i++) begin
            rd(5'h08, v);
            if (v[3]) break;
        end
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 1000; i++) begin
            rd(5'h0C, v);
            if (v == 8'hF8) break;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(5'h0C, v); chk("R1 status", v, 8'hF8);
        rd(5'h08, v); chk("R1 ctrl", v, 0);
        rd(5'h04, v); chk("R1 data", v, 0);
        rd(5'h00, v); chk("R1 own", v, 0);
        chk("R1 lines", {scl_o, sda_o}, 2'b11);
        // R12 plain registers and status write
        wr(5'h00, 8'h5A); wr(5'h10, 8'h3C); wr(5'h0C, 8'h44);
        rd(5'h00, v); chk("R12 own", v, 8'h5A);
        rd(5'h10, v); chk("R12 ext", v, 8'h3C);
        rd(5'h0C, v); chk("R12 status unchanged", v, 8'hF8);
        // R9 disabled START ignored
        wr(5'h08, 8'hA4);
        repeat (40) @(negedge clk);
        rd(5'h0C, v); chk("R9 status", v, 8'hF8);
        rd(5'h08, v); chk("R9 ctrl", v, 0);
        chk("R9 no start", n_start, 0);
        chk("R9 lines", {scl_o, sda_o}, 2'b11);
        // R2 START
        wr(5'h08, 8'h40);
        wr(5'h08, 8'hE0);
        wait_flag();
        rd(5'h0C, v); chk("R2 status", v, 8'h08);
        chk("R2 start seen", n_start, 1);
        rd(5'h08, v); chk("R12 ctrl readback", v, 8'hC8);
        chk("R10 irq set", irq, 1);
        repeat (20) @(negedge clk);
        chk("R11 scl held", scl_o, 0);
        // R4 address write acked
        slv_ack = 1;
        wr(5'h04, 8'hA0);
        wr(5'h08, 8'hC0);
        chk("R10 irq drop", irq, 0);
        wait_flag();
        rd(5'h0C, v); chk("R4 addr w ack", v, 8'h18);
        b = wq.pop_front(); chk("R4 addr byte", b, 8'hA0);
        // R5 data acked, irq off
        wr(5'h04, 8'h3C);
        wr(5'h08, 8'h40);
        wait_flag();
        rd(5'h0C, v); chk("R5 data ack", v, 8'h28);
        chk("R10 irq masked", irq, 0);
        b = wq.pop_front(); chk("R5 data byte", b, 8'h3C);
        // R5 data NAK
        slv_ack = 0;
        wr(5'h04, 8'h81);
        wr(5'h08, 8'h40);
        wait_flag();
        rd(5'h0C, v); chk("R5 data nak", v, 8'h30);
        b = wq.pop_front(); chk("R5 nak byte", b, 8'h81);
        // R3 repeated START
        wr(5'h08, 8'h60);
        wait_flag();
        rd(5'h0C, v); chk("R3 rstart", v, 8'h10);
        // R4 address read acked
        slv_ack = 1;
        rq.push_back(8'hC5); rq.push_back(8'h3A);
        wr(5'h04, 8'hA1);
        wr(5'h08, 8'h40);
        wait_flag();
        rd(5'h0C, v); chk("R4 addr r ack", v, 8'h40);
        void'(wq.pop_front());
        // R6 receive with ACK
        wr(5'h08, 8'h44);
        wait_flag();
        rd(5'h0C, v); chk("R6 rx ack", v, 8'h50);
        rd(5'h04, v); chk("R6 rx byte", v, 8'hC5);
        chk("R6 ack driven", m_ack, 1);
        // R6 receive with NAK
        wr(5'h08, 8'h40);
        wait_flag();
        rd(5'h0C, v); chk("R6 rx nak", v, 8'h58);
        rd(5'h04, v); chk("R6 rx byte2", v, 8'h3A);
        chk("R6 nak given", m_ack, 0);
        // R7 STOP
        wr(5'h08, 8'h50);
        rd(5'h08, v); chk("R7 flag cleared", v[3], 0);
        wait_idle();
        chk("R7 stop seen", n_stop, 1);
        rd(5'h08, v); chk("R7 no flag", v[3], 0);
        chk("R7 lines", {scl_o, sda_o}, 2'b11);
        // R2 fresh START after STOP, R4 NAK codes
        wr(5'h08, 8'h60);
        wait_flag();
        rd(5'h0C, v); chk("R2 fresh start", v, 8'h08);
        slv_ack = 0;
        wr(5'h04, 8'h91);
        wr(5'h08, 8'h40);
        wait_flag();
        rd(5'h0C, v); chk("R4 addr r nak", v, 8'h48);
        void'(wq.pop_front());
        wr(5'h08, 8'h60);
        wait_flag();
        rd(5'h0C, v); chk("R3 rstart2", v, 8'h10);
        wr(5'h04, 8'h90);
        wr(5'h08, 8'h40);
        wait_flag();
        rd(5'h0C, v); chk("R4 addr w nak", v, 8'h20);
        // R8 soft reset mid transfer
        wr(5'h1C, 8'h00);
        rd(5'h0C, v); chk("R8 status", v, 8'hF8);
        rd(5'h08, v); chk("R8 ctrl", v, 0);
        rd(5'h00, v); chk("R8 own", v, 0);
        rd(5'h10, v); chk("R8 ext", v, 0);
        chk("R8 lines", {scl_o, sda_o}, 2'b11);
        // R9 disable aborts an open transfer
        slv_ack = 1;
        wr(5'h08, 8'h40);
        wr(5'h08, 8'h60);
        wait_flag();
        rd(5'h0C, v); chk("R2 start after reset", v, 8'h08);
        wr(5'h08, 8'h00);
        rd(5'h0C, v); chk("R9 abort status", v, 8'hF8);
        rd(5'h08, v); chk("R9 abort ctrl", v, 0);
        chk("R9 abort lines", {scl_o, sda_o}, 2'b11);
        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule